// File: doc/BRIEF.md
# Prefix-Length-Ordered Ternary Table Update Engine

This block keeps a ternary longest-match table in order while prefixes are added and removed. Entries are grouped by prefix length. Lengths above the middle length are packed downward from address 0, longest first. Lengths at or below the middle length are packed upward from the last address, with length 0 at the bottom. The unused entries form one run between the two packs. Because a longer prefix always sits at a lower address than a shorter one, the lowest-address hit in a parallel search is the longest match.

The engine records the first address and the end address (one past the last entry) of every group. An insert opens a slot at the edge of the target group. For each group that lies between the target and the free run, the entry at the group's edge next to the free run is moved across to the group's other edge. A delete fills the freed slot with the boundary entry of its own group, then passes the resulting hole across each group between it and the free run. The final hole is written invalid. Each move is a read of the source entry followed by a write to the destination. Each group's bounds are updated on the same edge as that group's write.

The table storage sits outside the block and is reached through a read/write port with one cycle of read latency. Commands arrive on a single port and are accepted only while the engine is idle. Completion is reported by a one-cycle done pulse, with an error flag for commands that are rejected.

Top module: `lpo_update_engine`

## Requirements
- R1: After reset, `busy`, `done`, `err`, `tbl_re` and `tbl_we` are low. Every group is empty: groups longer than KEY_W/2 are at address 0, and the others are at address DEPTH.
- R2: After every completed command, each length group occupies a contiguous address range. Groups with length > KEY_W/2 are packed from address 0 in decreasing length. Groups with length <= KEY_W/2 are packed toward address DEPTH-1 in increasing length, ending with length 0. Every address between the two packs holds an entry with the valid bit at 0.
- R3: An inserted entry is written with these fields, from MSB to LSB: valid (bit 20) = 1, key [19:12] = command key with the bits below the prefix length cleared, care mask [11:4] with its top `len` bits set, and action [3:0].
- R4: An insert into the group next to the free run (length KEY_W/2+1, or length KEY_W/2) performs no reads and one write, and holds `busy` for one cycle.
- R5: For an insert into any other group, each group between the free run and the target costs two cycles (one read, then one write) if it is non-empty, or one cycle with no access if it is empty. The new entry is then written in one more cycle.
- R6: A delete moves the boundary entry of its own group into the freed slot, using one read and one write. This move is skipped when the freed slot is already that boundary entry. The delete then moves one entry across each non-empty group between the group and the free run, and finally writes an invalid entry (all zero) to the last hole.
- R7: An insert while no free entry remains completes with `done` and `err` high in the cycle after it is presented. `busy` never rises, and the table is not accessed.
- R8: A command with length > KEY_W, or a delete whose address is outside its length group, is rejected in the same way as in R7.
- R9: A command presented while `busy` is high is ignored.
- R10: An insert moves at most one entry per intervening group. With the defaults this is at most 4 moves, or half the 9 distinct lengths rounded down.
- R11: `done` is high for exactly one cycle, in the first cycle with `busy` low after a command. `err` is high only together with `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command present |
| cmd_del | input | 1 | 1 = delete, 0 = insert |
| cmd_len | input | LEN_W | Prefix length |
| cmd_key | input | KEY_W | Prefix value (insert) |
| cmd_act | input | ACT_W | Action (insert) |
| cmd_addr | input | TAW | Address of the entry to remove (delete) |
| busy | output | 1 | Update in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Command rejected, valid with done |
| tbl_re | output | 1 | Table read strobe |
| tbl_we | output | 1 | Table write strobe |
| tbl_addr | output | TAW | Table address |
| tbl_wdata | output | ENTRY_W | Entry to write |
| tbl_rdata | input | ENTRY_W | Entry read, one cycle after tbl_re |

## Verification
A wrong group bound inside the engine shows up at the ports on the next command that touches that group or any group it crosses. The read address, the number of busy cycles or the number of reads then differ from what the model's group counts predict. After that command completes, the table scan also finds a duplicated entry, a lost entry, or a valid entry inside the free run. A wrong hole register sends a write to the wrong address within the same command, so it is seen when that command's done pulse arrives.

// File: rtl/lpo_pkg.sv
package lpo_pkg;
    localparam int KEY_W   = 8;
    localparam int ACT_W   = 4;
    localparam int MID_LEN = KEY_W / 2;
    localparam int NGRP    = KEY_W + 1;
    localparam int LEN_W   = $clog2(KEY_W + 1);

    typedef struct packed {
        logic             vld;
        logic [KEY_W-1:0] key;
        logic [KEY_W-1:0] care;
        logic [ACT_W-1:0] act;
    } entry_t;

    localparam int ENTRY_W = $bits(entry_t);

    // bound adjustment applied to one group in one cycle
    typedef enum logic [2:0] {
        UPD_SHIFT_DN,   // both bounds +1
        UPD_SHIFT_UP,   // both bounds -1
        UPD_INC_START,
        UPD_DEC_LIM,
        UPD_INC_LIM,
        UPD_DEC_START
    } upd_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_STEP,
        ST_WR,
        ST_PUT,
        ST_CLR
    } state_e;

    function automatic logic [KEY_W-1:0] care_of(input logic [LEN_W-1:0] len);
        return ~({KEY_W{1'b1}} >> len);
    endfunction
endpackage

// File: rtl/lpo_bounds.sv
module lpo_bounds
    import lpo_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int PW    = $clog2(DEPTH + 1)
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       upd_en,
    input  logic [LEN_W-1:0]           upd_grp,
    input  upd_e                       upd_kind,
    output logic [NGRP-1:0][PW-1:0]    grp_start,
    output logic [NGRP-1:0][PW-1:0]    grp_lim
);
    for (genvar g = 0; g < NGRP; g++) begin : g_grp
        localparam logic [PW-1:0] INIT = (g > MID_LEN) ? '0 : PW'(DEPTH);
        logic [PW-1:0] s_q, l_q;
        logic          hit;

        assign hit = upd_en && (upd_grp == LEN_W'(g));

        always_ff @(posedge clk) begin
            if (rst) begin
                s_q <= INIT;
                l_q <= INIT;
            end else if (hit) begin
                case (upd_kind)
                    UPD_SHIFT_DN:  begin s_q <= s_q + PW'(1); l_q <= l_q + PW'(1); end
                    UPD_SHIFT_UP:  begin s_q <= s_q - PW'(1); l_q <= l_q - PW'(1); end
                    UPD_INC_START: s_q <= s_q + PW'(1);
                    UPD_DEC_LIM:   l_q <= l_q - PW'(1);
                    UPD_INC_LIM:   l_q <= l_q + PW'(1);
                    UPD_DEC_START: s_q <= s_q - PW'(1);
                    default: ;
                endcase
            end
        end

        assign grp_start[g] = s_q;
        assign grp_lim[g]   = l_q;
    end
endmodule

// File: rtl/lpo_step.sv
module lpo_step
    import lpo_pkg::*;
#(
    parameter int PW = 5
) (
    input  logic [LEN_W-1:0]        grp,
    input  logic [LEN_W-1:0]        tgt,
    input  logic                    asc,
    input  logic                    del,
    input  logic [PW-1:0]           hole,
    input  logic [NGRP-1:0][PW-1:0] grp_start,
    input  logic [NGRP-1:0][PW-1:0] grp_lim,
    output logic [PW-1:0]           src,
    output logic                    skip,
    output logic [LEN_W-1:0]        nxt_grp,
    output logic                    walk_end
);
    // ascending walks pull a group's first entry, descending walks its last
    assign src      = asc ? grp_start[grp] : grp_lim[grp] - PW'(1);
    assign skip     = (src == hole);
    assign nxt_grp  = asc ? grp + LEN_W'(1) : grp - LEN_W'(1);
    assign walk_end = del ? (asc ? (grp == LEN_W'(MID_LEN)) : (grp == LEN_W'(MID_LEN + 1)))
                          : (nxt_grp == tgt);
endmodule

// File: rtl/lpo_update_engine.sv
module lpo_update_engine
    import lpo_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int TAW  = $clog2(DEPTH),
    localparam int PW   = $clog2(DEPTH + 1)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cmd_valid,
    input  logic               cmd_del,
    input  logic [LEN_W-1:0]   cmd_len,
    input  logic [KEY_W-1:0]   cmd_key,
    input  logic [ACT_W-1:0]   cmd_act,
    input  logic [TAW-1:0]     cmd_addr,
    output logic               busy,
    output logic               done,
    output logic               err,
    output logic               tbl_re,
    output logic               tbl_we,
    output logic [TAW-1:0]     tbl_addr,
    output logic [ENTRY_W-1:0] tbl_wdata,
    input  logic [ENTRY_W-1:0] tbl_rdata
);
    localparam logic [LEN_W-1:0] UP_FIRST = LEN_W'(MID_LEN + 1);
    localparam logic [LEN_W-1:0] LO_FIRST = LEN_W'(MID_LEN);

    state_e                    state_q;
    logic [LEN_W-1:0]          grp_q, tgt_q;
    logic [PW-1:0]             hole_q;
    logic                      del_q, asc_q, first_q;
    entry_t                    new_q;

    logic [NGRP-1:0][PW-1:0]   grp_start, grp_lim;
    logic [PW-1:0]             up_end, lo_begin, src;
    logic                      skip, walk_end, upd_en;
    logic [LEN_W-1:0]          nxt_grp, upd_grp, cl_len, init_grp;
    upd_e                      upd_kind;

    logic len_ok, in_grp, reject, cmd_asc;
    logic [PW-1:0] addr_w, init_hole;

    assign up_end   = grp_lim[MID_LEN + 1];
    assign lo_begin = grp_start[MID_LEN];

    lpo_bounds #(.DEPTH(DEPTH), .PW(PW)) u_bounds (
        .clk(clk), .rst(rst), .upd_en(upd_en), .upd_grp(upd_grp),
        .upd_kind(upd_kind), .grp_start(grp_start), .grp_lim(grp_lim)
    );

    lpo_step #(.PW(PW)) u_step (
        .grp(grp_q), .tgt(tgt_q), .asc(asc_q), .del(del_q), .hole(hole_q),
        .grp_start(grp_start), .grp_lim(grp_lim),
        .src(src), .skip(skip), .nxt_grp(nxt_grp), .walk_end(walk_end)
    );

    // command screening
    assign len_ok    = (cmd_len <= LEN_W'(KEY_W));
    assign cl_len    = len_ok ? cmd_len : '0;
    assign addr_w    = PW'(cmd_addr);
    assign in_grp    = (addr_w >= grp_start[cl_len]) && (addr_w < grp_lim[cl_len]);
    assign reject    = !len_ok || (cmd_del ? !in_grp : (up_end == lo_begin));
    assign cmd_asc   = cmd_del ? (cmd_len <= LEN_W'(MID_LEN)) : (cmd_len > LEN_W'(MID_LEN));
    assign init_grp  = cmd_del ? cmd_len : (cmd_asc ? UP_FIRST : LO_FIRST);
    assign init_hole = cmd_del ? addr_w : (cmd_asc ? up_end : lo_begin - PW'(1));

    // bound register update: one group per cycle, on the cycle its write lands
    always_comb begin
        upd_en   = 1'b0;
        upd_grp  = grp_q;
        upd_kind = asc_q ? UPD_SHIFT_DN : UPD_SHIFT_UP;
        case (state_q)
            ST_STEP: upd_en = skip;
            ST_WR:   upd_en = 1'b1;
            ST_PUT: begin
                upd_en   = 1'b1;
                upd_grp  = tgt_q;
                upd_kind = asc_q ? UPD_INC_LIM : UPD_DEC_START;
            end
            default: ;
        endcase
        if (state_q != ST_PUT && del_q && first_q)
            upd_kind = asc_q ? UPD_INC_START : UPD_DEC_LIM;
    end

    // table port
    always_comb begin
        tbl_re    = (state_q == ST_STEP) && !skip;
        tbl_we    = (state_q == ST_WR) || (state_q == ST_PUT) || (state_q == ST_CLR);
        tbl_addr  = (state_q == ST_STEP) ? TAW'(src) : TAW'(hole_q);
        tbl_wdata = '0;
        if (state_q == ST_WR)  tbl_wdata = tbl_rdata;
        if (state_q == ST_PUT) tbl_wdata = new_q;
    end

    assign busy = (state_q != ST_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            done    <= 1'b0;
            err     <= 1'b0;
            grp_q   <= '0;
            tgt_q   <= '0;
            hole_q  <= '0;
            del_q   <= 1'b0;
            asc_q   <= 1'b0;
            first_q <= 1'b0;
            new_q   <= '0;
        end else begin
            done <= 1'b0;
            err  <= 1'b0;
            case (state_q)
                ST_IDLE: if (cmd_valid) begin
                    if (reject) begin
                        done <= 1'b1;
                        err  <= 1'b1;
                    end else begin
                        del_q    <= cmd_del;
                        asc_q    <= cmd_asc;
                        first_q  <= cmd_del;
                        tgt_q    <= cmd_len;
                        grp_q    <= init_grp;
                        hole_q   <= init_hole;
                        new_q    <= '{vld: 1'b1, key: cmd_key & care_of(cmd_len),
                                      care: care_of(cmd_len), act: cmd_act};
                        state_q  <= (!cmd_del && init_grp == cmd_len) ? ST_PUT : ST_STEP;
                    end
                end
                ST_STEP, ST_WR: if (state_q == ST_WR || skip) begin
                    hole_q  <= src;
                    first_q <= 1'b0;
                    grp_q   <= nxt_grp;
                    state_q <= walk_end ? (del_q ? ST_CLR : ST_PUT) : ST_STEP;
                end else begin
                    state_q <= ST_WR;
                end
                ST_PUT, ST_CLR: begin
                    done    <= 1'b1;
                    state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/lpo_update_engine_chk.sv
module lpo_update_engine_chk #(
    parameter int PW = 5
) (
    input logic          clk,
    input logic          rst,
    input logic          busy,
    input logic          done,
    input logic          err,
    input logic          tbl_re,
    input logic          tbl_we,
    input logic [PW-1:0] up_end,
    input logic [PW-1:0] lo_begin
);
    AST_NO_DUAL_ACCESS: assert property (@(posedge clk) disable iff (rst)
        !(tbl_re && tbl_we)); // R6
    AST_READ_THEN_WRITE: assert property (@(posedge clk) disable iff (rst)
        tbl_re |=> tbl_we); // R5
    AST_ERR_WITH_DONE: assert property (@(posedge clk) disable iff (rst)
        err |-> done); // R11
    AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy); // R11
    AST_ACCESS_ONLY_BUSY: assert property (@(posedge clk) disable iff (rst)
        (tbl_re || tbl_we) |-> busy); // R7
    AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (rst)
        up_end <= lo_begin); // R2
endmodule

bind lpo_update_engine lpo_update_engine_chk #(.PW(PW)) u_chk (.*);

// File: tb/lpo_update_engine_test.sv
`timescale 1ns/1ps
module lpo_update_engine_test;
    import lpo_pkg::*;
    localparam int DEPTH = 16;
    localparam int TAW   = $clog2(DEPTH);
    localparam int KW    = KEY_W;
    localparam int MID   = MID_LEN;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic rst, cmd_valid, cmd_del, busy, done, err, tbl_re, tbl_we;
    logic [LEN_W-1:0] cmd_len;
    logic [KEY_W-1:0] cmd_key;
    logic [ACT_W-1:0] cmd_act;
    logic [TAW-1:0] cmd_addr, tbl_addr;
    logic [ENTRY_W-1:0] tbl_wdata, tbl_rdata;
    entry_t mem [DEPTH];

    lpo_update_engine #(.DEPTH(DEPTH)) uut (.*);

    always @(posedge clk) begin
        if (rst) begin
            for (int a = 0; a < DEPTH; a++) mem[a] <= '0;
            tbl_rdata <= '0;
        end else begin
            if (tbl_we) mem[tbl_addr] <= entry_t'(tbl_wdata);
            if (tbl_re) tbl_rdata <= mem[tbl_addr];
        end
    end

    int n_cmp = 0, n_bad = 0, cyc = 0;
    int cnt [NGRP];
    logic [KEY_W-1:0] mk [NGRP][$];
    logic [ACT_W-1:0] ma [NGRP][$];

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial forever begin
        @(posedge clk);
        cyc++;
        if (cyc >= 100000) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog actual=%0d expected=<%0d", cyc, 100000);
            summary();
        end
    end

    task automatic chk(input bit ok, input string req, input string what, input int av, input int ev);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, av, ev);
        end
    endtask

    function automatic logic [KEY_W-1:0] mask_of(input int len);
        logic [KEY_W-1:0] m = '0;
        for (int i = 0; i < len; i++) m[KW-1-i] = 1'b1;
        return m;
    endfunction

    function automatic int grp_lo(input int L);
        int s = 0;
        if (L > MID) begin
            for (int g = KW; g > L; g--) s += cnt[g];
        end else begin
            s = DEPTH;
            for (int g = 0; g <= L; g++) s -= cnt[g];
        end
        return s;
    endfunction

    function automatic int total();
        int t = 0;
        for (int g = 0; g < NGRP; g++) t += cnt[g];
        return t;
    endfunction

    function automatic int find_addr(input int len, input logic [KEY_W-1:0] key, input logic [ACT_W-1:0] act);
        for (int a = 0; a < DEPTH; a++)
            if (mem[a].vld && $countones(mem[a].care) == len && mem[a].key == key && mem[a].act == act)
                return a;
        return -1;
    endfunction

    // layout and contents of the whole table against the model
    task automatic scan();
        int exp_len [DEPTH];
        int bad_a = -1, bad_l = 0, missing = 0;
        for (int a = 0; a < DEPTH; a++) exp_len[a] = -1;
        for (int L = 0; L < NGRP; L++)
            for (int a = grp_lo(L); a < grp_lo(L) + cnt[L]; a++) exp_len[a] = L;
        for (int a = 0; a < DEPTH; a++) begin
            if (exp_len[a] < 0) begin
                if (mem[a].vld && bad_a < 0) begin bad_a = a; bad_l = -1; end
            end else if (!mem[a].vld || $countones(mem[a].care) != exp_len[a] ||
                         mem[a].care != mask_of(exp_len[a]) || (mem[a].key & ~mem[a].care) != 0) begin
                if (bad_a < 0) begin bad_a = a; bad_l = exp_len[a]; end
            end
        end
        chk(bad_a < 0, "R2", "layout: first bad address", bad_a, -1);
        for (int L = 0; L < NGRP; L++)
            foreach (mk[L][i]) begin
                int a = find_addr(L, mk[L][i], ma[L][i]);
                if (a < 0 || exp_len[a] != L) missing++;
            end
        chk(missing == 0, "R3", "entries not found in their group", missing, 0);
        if (bad_a >= 0) $display("  note: address %0d expected length %0d", bad_a, bad_l);
    endtask

    function automatic void cost(input int g, inout int c, inout int m);
        if (cnt[g] > 0) begin c += 2; m += 1; end
        else c += 1;
    endfunction

    task automatic do_cmd(input bit del, input int len, input logic [KEY_W-1:0] key,
                          input logic [ACT_W-1:0] act, input int addr, input bit junk, input string req);
        bit exp_err = 0;
        int exp_cyc = 0, exp_mv = 0, bcyc = 0, rcnt = 0, lo, hi, n = 0;
        bit seen = 0, gap = 0;
        entry_t snap [DEPTH];
        entry_t victim;
        for (int a = 0; a < DEPTH; a++) snap[a] = mem[a];
        if (len > KW) exp_err = 1;
        else if (!del) begin
            if (total() == DEPTH) exp_err = 1;
            else if (len > MID) begin
                for (int g = MID + 1; g < len; g++) cost(g, exp_cyc, exp_mv);
                exp_cyc += 1;
            end else begin
                for (int g = MID; g > len; g--) cost(g, exp_cyc, exp_mv);
                exp_cyc += 1;
            end
        end else begin
            lo = grp_lo(len); hi = lo + cnt[len];
            if (addr < lo || addr >= hi) exp_err = 1;
            else if (len > MID) begin
                if (addr == hi - 1) exp_cyc += 1; else begin exp_cyc += 2; exp_mv += 1; end
                for (int g = len - 1; g > MID; g--) cost(g, exp_cyc, exp_mv);
                exp_cyc += 1;
            end else begin
                if (addr == lo) exp_cyc += 1; else begin exp_cyc += 2; exp_mv += 1; end
                for (int g = len + 1; g <= MID; g++) cost(g, exp_cyc, exp_mv);
                exp_cyc += 1;
            end
        end

        @(negedge clk);
        cmd_valid = 1; cmd_del = del; cmd_len = LEN_W'(len); cmd_key = key;
        cmd_act = act; cmd_addr = TAW'(addr);
        @(negedge clk);
        if (junk) begin
            cmd_valid = 1; cmd_del = 0; cmd_len = 3; cmd_key = 8'hEE; cmd_act = 4'hF;
        end else cmd_valid = 0;
        while (n < 300) begin
            if (done) begin seen = 1; break; end
            if (busy) bcyc++; else gap = 1;
            if (tbl_re) rcnt++;
            n++;
            @(negedge clk);
        end
        cmd_valid = 0;
        chk(seen && !gap, "R11", "done after continuous busy", int'(seen), 1);
        chk(err == exp_err, req, "err flag", int'(err), int'(exp_err));
        chk(bcyc == exp_cyc, req, "busy cycles", bcyc, exp_cyc);
        chk(rcnt == exp_mv, req, "entry moves (reads)", rcnt, exp_mv);
        @(negedge clk);
        chk(!done && !busy, "R11", "done lasts one cycle", int'(done), 0);
        if (exp_err) begin
            int diffs = 0;
            for (int a = 0; a < DEPTH; a++) if (mem[a] != snap[a]) diffs++;
            chk(diffs == 0, req, "table changed by rejected command", diffs, 0);
        end else if (!del) begin
            cnt[len]++;
            mk[len].push_back(key & mask_of(len));
            ma[len].push_back(act);
        end else begin
            victim = snap[addr];
            foreach (mk[len][i])
                if (mk[len][i] == victim.key && ma[len][i] == victim.act) begin
                    mk[len].delete(i); ma[len].delete(i); break;
                end
            cnt[len]--;
        end
        scan();
    endtask

    initial begin
        for (int g = 0; g < NGRP; g++) cnt[g] = 0;
        rst = 1; cmd_valid = 0; cmd_del = 0; cmd_len = 0; cmd_key = 0; cmd_act = 0; cmd_addr = 0;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        chk(!busy && !done && !err && !tbl_re && !tbl_we, "R1", "idle outputs after reset",
            int'(busy) + int'(done) + int'(err) + int'(tbl_re) + int'(tbl_we), 0);
        scan();

        do_cmd(0, 5, 8'hC8, 4'h1, 0, 0, "R4");
        do_cmd(0, 8, 8'h11, 4'h2, 0, 0, "R5");
        do_cmd(0, 4, 8'h30, 4'h3, 0, 0, "R4");
        do_cmd(0, 0, 8'h00, 4'h4, 0, 0, "R5");
        do_cmd(0, 2, 8'h40, 4'h5, 0, 0, "R5");
        do_cmd(0, 3, 8'h60, 4'h6, 0, 0, "R5");
        do_cmd(0, 1, 8'h80, 4'h7, 0, 0, "R5");
        do_cmd(0, 7, 8'h22, 4'h8, 0, 0, "R5");
        do_cmd(0, 6, 8'h24, 4'h9, 0, 0, "R5");
        do_cmd(0, 0, 8'h00, 4'hA, 0, 0, "R10");

        do_cmd(1, 8, 0, 0, find_addr(8, 8'h11, 4'h2), 0, "R6");
        do_cmd(1, 2, 0, 0, find_addr(2, 8'h40, 4'h5), 0, "R6");
        do_cmd(1, 0, 0, 0, grp_lo(0) + 1, 0, "R6");
        do_cmd(0, 3, 8'h70, 4'hB, 0, 1, "R9");
        do_cmd(0, 9, 8'h00, 4'h0, 0, 0, "R8");

        do_cmd(0, 8, 8'h12, 4'h1, 0, 0, "R5");
        do_cmd(0, 7, 8'h26, 4'h2, 0, 0, "R5");
        do_cmd(0, 6, 8'h28, 4'h3, 0, 0, "R5");
        do_cmd(0, 5, 8'hD0, 4'h4, 0, 0, "R4");
        do_cmd(0, 4, 8'h50, 4'h5, 0, 0, "R4");
        do_cmd(0, 3, 8'hA0, 4'h6, 0, 0, "R5");
        do_cmd(0, 2, 8'hC0, 4'h7, 0, 0, "R5");
        do_cmd(0, 1, 8'h00, 4'h8, 0, 0, "R10");
        chk(total() == DEPTH, "R7", "table filled", total(), DEPTH);
        do_cmd(0, 5, 8'hE8, 4'hC, 0, 0, "R7");
        do_cmd(1, 5, 0, 0, 0, 0, "R8");
        do_cmd(1, 9, 0, 0, 3, 0, "R8");
        do_cmd(1, 4, 0, 0, find_addr(4, 8'h30, 4'h3), 0, "R6");
        do_cmd(1, 7, 0, 0, find_addr(7, 8'h22, 4'h8), 0, "R6");

        summary();
    end
endmodule